// File: doc/BRIEF.md
# SPI NOR Flash Responder

This block stands in for a small serial NOR flash on the far side of an SPI link. It is meant as a target when verifying a flash controller. It follows chip select, serial clock and MOSI through a synchroniser on its own system clock. After each falling edge of chip select it decodes a one-byte command, collects a big-endian address, and then either stores one byte in an internal array or shifts a stored byte back out on MISO.

Three commands are understood. The first is a write-enable command, which must be framed on its own. The second is a single-byte program, which only takes effect when the write-enable latch is set. The third is a plain read. Programming can only clear bits. The array comes out of reset fully erased. Only the low address bits select a byte, so a controller can use any 24-bit address without a full-size model. The link runs in SPI mode 0: SCK idles low, MOSI is sampled on the rising edge and MISO changes on the falling edge.

Top module: `spi_flash_resp`

## Requirements
- R1: After reset every array byte reads 0xFF, the write-enable latch is clear, and both `spi_miso` and `spi_miso_oe` are 0.
- R2: While chip select is high, and during the command and address bytes of any transaction, `spi_miso_oe` is 0 and `spi_miso` is 0.
- R3: Command 0x03 followed by three address bytes (most significant byte first, each bit sampled on a rising SCK edge, MSB first) makes the block drive the addressed byte during the next byte time. It is driven MSB first with `spi_miso_oe` high, each bit changing only after a falling SCK edge and stable while SCK is high.
- R4: Command 0x06 sets the write-enable latch only when chip select rises after exactly 8 clocked bits. With 9 bits, or with 0x06 followed by another byte in the same frame, the latch is not set.
- R5: Command 0x02, three address bytes and one data byte, with the latch set and chip select rising on a byte boundary, programs the addressed byte.
- R6: A program command while the latch is clear leaves the array unchanged.
- R7: A program frame that ends with a partial byte (chip select rising when the bit count is not a multiple of 8) leaves the array unchanged.
- R8: The latch is cleared at the end of every program frame, whether or not it wrote; a second program without a fresh write enable has no effect.
- R9: A command byte other than 0x02, 0x03 or 0x06 is ignored until the next chip select fall: MISO is not driven and the write-enable latch keeps its value.
- R10: Only the low log2(DEPTH) address bits select a byte; the upper address bits have no effect on read or program.
- R11: Programming stores the bitwise AND of the old byte and the new byte, so a bit once 0 stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the SPI lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Active-low chip select from the controller |
| spi_sck | input | 1 | Serial clock, idle low (mode 0) |
| spi_mosi | input | 1 | Serial data from the controller |
| spi_miso | output | 1 | Serial read data, 0 when not driven |
| spi_miso_oe | output | 1 | High while the block is driving read data |

## Verification
The bench uses the defaults: a 256-byte array, 24-bit addresses, two synchroniser stages and AND-style programming, with SCK running at one sixteenth of the system clock. With 256 bytes, an address such as 0xABCD40 folds onto index 0x40, so aliasing of the upper address bits shows up through ordinary reads. Both ends of the index range, 0x00 and 0xFF, are read straight after reset. The slow SCK leaves room for the synchroniser delay, so MISO can be sampled just before each rising edge, in the same way a real controller would.

// File: rtl/flash_resp_pkg.sv
package flash_resp_pkg;

   localparam logic [7:0] CMD_READ = 8'h03;
   localparam logic [7:0] CMD_PROG = 8'h02;
   localparam logic [7:0] CMD_WREN = 8'h06;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CMD,
      ST_ADDR,
      ST_RDDATA,
      ST_PGDATA,
      ST_PGDONE,
      ST_WREN,
      ST_SKIP
   } resp_state_t;

endpackage

// File: rtl/flash_resp_sync.sv
module flash_resp_sync #(
   parameter int               W       = 3,
   parameter int               STAGES  = 2,
   parameter logic [W-1:0]     RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_in,
   output logic [W-1:0] q_out
);

   initial assert (STAGES >= 0 && STAGES <= 4)
      else $error("flash_resp_sync: STAGES out of range");

   generate
      if (STAGES == 0) begin : g_bypass
         assign q_out = d_in;
      end else begin : g_chain
         logic [W-1:0] stg [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
            end else begin
               stg[0] <= d_in;
               for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
            end
         end
         assign q_out = stg[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/flash_resp_rx.sv
module flash_resp_rx (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cs_fall,
   input  logic       sck_rise,
   input  logic       mosi_s,
   output logic       byte_done,
   output logic [7:0] byte_val,
   output logic       on_boundary
);

   logic [2:0] bit_cnt;
   logic [6:0] shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt <= '0;
         shreg   <= '0;
      end else if (cs_fall) begin
         bit_cnt <= '0;
      end else if (sck_rise) begin
         bit_cnt <= bit_cnt + 3'd1;
         shreg   <= {shreg[5:0], mosi_s};
      end
   end

   assign byte_done   = sck_rise && (bit_cnt == 3'd7);
   assign byte_val    = {shreg, mosi_s};
   assign on_boundary = (bit_cnt == 3'd0);

   // R7
   boundary_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      byte_done |=> on_boundary);

endmodule

// File: rtl/flash_resp_mem.sv
module flash_resp_mem #(
   parameter int DEPTH    = 256,
   parameter bit PROG_AND = 1'b1,
   localparam int IDX_W   = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [7:0]       rd_data,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [7:0]       wr_data
);

   initial assert (DEPTH >= 2 && (1 << IDX_W) == DEPTH)
      else $error("flash_resp_mem: DEPTH must be a power of two");

   logic [7:0] mem_q [DEPTH];
   logic [7:0] old_byte;
   logic [7:0] new_byte;

   assign old_byte = mem_q[wr_idx];
   assign rd_data  = mem_q[rd_idx];

   generate
      if (PROG_AND) begin : g_and
         assign new_byte = old_byte & wr_data;
         // R11
         no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en |=> ((mem_q[$past(wr_idx)] & ~$past(old_byte)) == 8'h00));
      end else begin : g_over
         assign new_byte = wr_data;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
      end else if (wr_en) begin
         mem_q[wr_idx] <= new_byte;
      end
   end

endmodule

// File: rtl/flash_resp_ctrl.sv
module flash_resp_ctrl
   import flash_resp_pkg::*;
#(
   parameter int  ADDR_W = 24,
   parameter int  IDX_W  = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_fall,
   input  logic             cs_rise,
   input  logic             sck_fall,
   input  logic             byte_done,
   input  logic [7:0]       byte_val,
   input  logic             on_boundary,
   output logic [IDX_W-1:0] rd_idx,
   input  logic [7:0]       rd_data,
   output logic             wr_en,
   output logic [IDX_W-1:0] wr_idx,
   output logic [7:0]       wr_data,
   output logic             miso,
   output logic             miso_oe
);

   localparam int ADDR_BYTES = ADDR_W / 8;
   localparam int CNT_W      = $clog2(ADDR_BYTES + 1);

   initial assert (ADDR_W >= 16 && ADDR_W % 8 == 0 && IDX_W <= ADDR_W)
      else $error("flash_resp_ctrl: bad ADDR_W / IDX_W");

   resp_state_t      state;
   logic [ADDR_W-1:0] addr_q;
   logic [ADDR_W-1:0] addr_next;
   logic [CNT_W-1:0] addr_cnt;
   logic             is_rd;
   logic             is_pg;
   logic             wel_q;
   logic [7:0]       pend_q;
   logic [7:0]       tx_q;
   logic             miso_q;

   assign addr_next = {addr_q[ADDR_W-9:0], byte_val};
   assign rd_idx    = addr_next[IDX_W-1:0];
   assign wr_idx    = addr_q[IDX_W-1:0];
   assign wr_data   = pend_q;
   assign wr_en     = cs_rise && (state == ST_PGDONE) && on_boundary && wel_q;
   assign miso      = miso_q;
   assign miso_oe   = (state == ST_RDDATA);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         addr_q   <= '0;
         addr_cnt <= '0;
         is_rd    <= 1'b0;
         is_pg    <= 1'b0;
         wel_q    <= 1'b0;
         pend_q   <= 8'hFF;
         tx_q     <= 8'h00;
         miso_q   <= 1'b0;
      end else if (cs_fall) begin
         state    <= ST_CMD;
         addr_cnt <= '0;
         miso_q   <= 1'b0;
      end else if (cs_rise) begin
         state  <= ST_IDLE;
         miso_q <= 1'b0;
         is_pg  <= 1'b0;
         is_rd  <= 1'b0;
         if (state == ST_WREN && on_boundary) wel_q <= 1'b1;
         if (is_pg) wel_q <= 1'b0;
      end else begin
         if (byte_done) begin
            unique case (state)
               ST_CMD: begin
                  if (byte_val == CMD_READ) begin
                     state <= ST_ADDR;
                     is_rd <= 1'b1;
                  end else if (byte_val == CMD_PROG) begin
                     state <= ST_ADDR;
                     is_pg <= 1'b1;
                  end else if (byte_val == CMD_WREN) begin
                     state <= ST_WREN;
                  end else begin
                     state <= ST_SKIP;
                  end
               end
               ST_ADDR: begin
                  addr_q   <= addr_next;
                  addr_cnt <= addr_cnt + 1'b1;
                  if (addr_cnt == CNT_W'(ADDR_BYTES - 1)) begin
                     if (is_rd) begin
                        state <= ST_RDDATA;
                        tx_q  <= rd_data;
                     end else begin
                        state <= ST_PGDATA;
                     end
                  end
               end
               ST_PGDATA: begin
                  pend_q <= byte_val;
                  state  <= ST_PGDONE;
               end
               ST_WREN:   state <= ST_SKIP;
               default:   ;
            endcase
         end
         if (sck_fall && state == ST_RDDATA) begin
            miso_q <= tx_q[7];
            tx_q   <= {tx_q[6:0], 1'b0};
         end
      end
   end

   // R8
   wel_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !wel_q);

   // R4
   wel_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wel_q) |-> $past(cs_rise));

   // R6
   prog_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_rise && !wel_q) |-> !wr_en);

endmodule

// File: rtl/spi_flash_resp.sv
module spi_flash_resp #(
   parameter int ADDR_W      = 24,
   parameter int DEPTH       = 256,
   parameter int SYNC_STAGES = 2,
   parameter bit PROG_AND    = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic spi_cs_n,
   input  logic spi_sck,
   input  logic spi_mosi,
   output logic spi_miso,
   output logic spi_miso_oe
);

   localparam int IDX_W = $clog2(DEPTH);

   logic [2:0]       pins_s;
   logic             cs_s, sck_s, mosi_s;
   logic             cs_q, sck_q;
   logic             cs_fall, cs_rise, sck_rise, sck_fall;
   logic             byte_done, on_boundary;
   logic [7:0]       byte_val;
   logic [IDX_W-1:0] rd_idx, wr_idx;
   logic [7:0]       rd_data, wr_data;
   logic             wr_en;

   flash_resp_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  ({spi_cs_n, spi_sck, spi_mosi}),
      .q_out (pins_s)
   );

   assign cs_s   = pins_s[2];
   assign sck_s  = pins_s[1];
   assign mosi_s = pins_s[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_q  <= 1'b1;
         sck_q <= 1'b0;
      end else begin
         cs_q  <= cs_s;
         sck_q <= sck_s;
      end
   end

   assign cs_fall  = cs_q && !cs_s;
   assign cs_rise  = !cs_q && cs_s;
   assign sck_rise = sck_s && !sck_q && !cs_s;
   assign sck_fall = !sck_s && sck_q && !cs_s;

   flash_resp_rx u_rx (
      .clk         (clk),
      .rst_n       (rst_n),
      .cs_fall     (cs_fall),
      .sck_rise    (sck_rise),
      .mosi_s      (mosi_s),
      .byte_done   (byte_done),
      .byte_val    (byte_val),
      .on_boundary (on_boundary)
   );

   flash_resp_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .cs_fall     (cs_fall),
      .cs_rise     (cs_rise),
      .sck_fall    (sck_fall),
      .byte_done   (byte_done),
      .byte_val    (byte_val),
      .on_boundary (on_boundary),
      .rd_idx      (rd_idx),
      .rd_data     (rd_data),
      .wr_en       (wr_en),
      .wr_idx      (wr_idx),
      .wr_data     (wr_data),
      .miso        (spi_miso),
      .miso_oe     (spi_miso_oe)
   );

   flash_resp_mem #(.DEPTH(DEPTH), .PROG_AND(PROG_AND)) u_mem (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_idx  (rd_idx),
      .rd_data (rd_data),
      .wr_en   (wr_en),
      .wr_idx  (wr_idx),
      .wr_data (wr_data)
   );

   // R2
   cs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_s && cs_q) |-> (!spi_miso_oe && !spi_miso));

   // R3
   miso_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sck_s && sck_q) |-> $stable(spi_miso));

endmodule

// File: tb/sim_spi_flash_resp.sv
module sim_spi_flash_resp;

   localparam int CLK_PERIOD = 10;
   localparam int HALF       = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic spi_cs_n = 1'b1;
   logic spi_sck = 1'b0;
   logic spi_mosi = 1'b0;
   logic spi_miso;
   logic spi_miso_oe;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   spi_flash_resp u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .spi_cs_n    (spi_cs_n),
      .spi_sck     (spi_sck),
      .spi_mosi    (spi_mosi),
      .spi_miso    (spi_miso),
      .spi_miso_oe (spi_miso_oe)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic cs_on();
      @(negedge clk) spi_cs_n = 1'b0;
      repeat (HALF) @(negedge clk);
   endtask

   task automatic cs_off();
      repeat (HALF) @(negedge clk);
      spi_cs_n = 1'b1;
      repeat (3*HALF) @(negedge clk);
   endtask

   // sends the top n bits of b, MSB first; returns sampled MISO and enable flags
   task automatic send_bits(input logic [7:0] b, input int n, output logic [7:0] r,
                            output logic oe_all, output logic oe_any);
      r = 8'h00; oe_all = 1'b1; oe_any = 1'b0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk) spi_mosi = b[7-i];
         repeat (HALF) @(negedge clk);
         r = {r[6:0], spi_miso};
         oe_all = oe_all & spi_miso_oe;
         oe_any = oe_any | spi_miso_oe;
         spi_sck = 1'b1;
         repeat (HALF) @(negedge clk);
         spi_sck = 1'b0;
      end
   endtask

   task automatic send_byte(input logic [7:0] b, output logic oe_any);
      logic [7:0] r;
      logic       a;
      send_bits(b, 8, r, a, oe_any);
   endtask

   task automatic do_read(input logic [23:0] addr, output logic [7:0] d,
                          output logic oe_all, output logic hdr_oe);
      logic o0, o1, o2, o3, x;
      cs_on();
      send_byte(8'h03, o0);
      send_byte(addr[23:16], o1);
      send_byte(addr[15:8], o2);
      send_byte(addr[7:0], o3);
      send_bits(8'hFF, 8, d, oe_all, x);
      hdr_oe = o0 | o1 | o2 | o3;
      cs_off();
   endtask

   task automatic do_wren();
      logic o;
      cs_on(); send_byte(8'h06, o); cs_off();
   endtask

   task automatic do_prog(input logic [23:0] addr, input logic [7:0] d);
      logic o;
      cs_on();
      send_byte(8'h02, o);
      send_byte(addr[23:16], o);
      send_byte(addr[15:8], o);
      send_byte(addr[7:0], o);
      send_byte(d, o);
      cs_off();
   endtask

   task automatic read_chk(input string req, input logic [23:0] addr, input logic [7:0] exp);
      logic [7:0] d;
      logic oa, ho;
      do_read(addr, d, oa, ho);
      chk(req, d, exp);
   endtask

   task automatic t_reset();
      logic [7:0] d;
      logic oa, ho;
      chk("R1 miso after reset", {7'd0, spi_miso}, 8'h00);
      chk("R1 oe after reset", {7'd0, spi_miso_oe}, 8'h00);
      read_chk("R1 erased byte 0x00", 24'h000000, 8'hFF);
      do_read(24'h0000FF, d, oa, ho);
      chk("R1 erased byte 0xFF", d, 8'hFF);
      chk("R3 oe during data byte", {7'd0, oa}, 8'h01);
      chk("R2 oe during header", {7'd0, ho}, 8'h00);
      chk("R2 oe with cs high", {7'd0, spi_miso_oe}, 8'h00);
      chk("R2 miso with cs high", {7'd0, spi_miso}, 8'h00);
      do_prog(24'h000001, 8'h00);
      read_chk("R1 latch clear after reset", 24'h000001, 8'hFF);
   endtask

   task automatic t_program();
      do_wren();
      do_prog(24'h000010, 8'hA5);
      read_chk("R5 programmed byte", 24'h000010, 8'hA5);
      read_chk("R3 neighbour untouched", 24'h000011, 8'hFF);
   endtask

   task automatic t_and();
      do_wren();
      do_prog(24'h000010, 8'h5A);
      read_chk("R11 and with old byte", 24'h000010, 8'h00);
      do_wren();
      do_prog(24'h000012, 8'h0F);
      do_wren();
      do_prog(24'h000012, 8'hF3);
      read_chk("R11 bits only clear", 24'h000012, 8'h03);
   endtask

   task automatic t_no_wel();
      do_prog(24'h000020, 8'h00);
      read_chk("R6 program without latch", 24'h000020, 8'hFF);
   endtask

   task automatic t_wel_clear();
      do_wren();
      do_prog(24'h000021, 8'h33);
      read_chk("R8 first program", 24'h000021, 8'h33);
      do_prog(24'h000022, 8'h00);
      read_chk("R8 second program ignored", 24'h000022, 8'hFF);
   endtask

   task automatic t_wren_bits();
      logic [7:0] r;
      logic a, b, o;
      cs_on(); send_bits(8'h06, 8, r, a, b); send_bits(8'h00, 1, r, a, b); cs_off();
      do_prog(24'h000023, 8'h00);
      read_chk("R4 wren with 9 bits", 24'h000023, 8'hFF);
      cs_on(); send_byte(8'h06, o); send_byte(8'h02, o); cs_off();
      do_prog(24'h000023, 8'h00);
      read_chk("R4 wren with extra byte", 24'h000023, 8'hFF);
      do_wren();
      do_prog(24'h000023, 8'h81);
      read_chk("R4 exact wren", 24'h000023, 8'h81);
   endtask

   task automatic t_partial();
      logic [7:0] r;
      logic a, b, o;
      do_wren();
      cs_on();
      send_byte(8'h02, o); send_byte(8'h00, o); send_byte(8'h00, o); send_byte(8'h24, o);
      send_byte(8'h00, o);
      send_bits(8'h00, 3, r, a, b);
      cs_off();
      read_chk("R7 partial byte frame", 24'h000024, 8'hFF);
      do_prog(24'h000024, 8'h00);
      read_chk("R8 latch cleared by failed program", 24'h000024, 8'hFF);
   endtask

   task automatic t_unknown();
      logic o0, o1, o2;
      do_wren();
      cs_on(); send_byte(8'h9F, o0); send_byte(8'h00, o1); send_byte(8'h00, o2); cs_off();
      chk("R9 no drive on unknown command", {7'd0, o0 | o1 | o2}, 8'h00);
      do_prog(24'h000025, 8'h42);
      read_chk("R9 latch kept", 24'h000025, 8'h42);
   endtask

   task automatic t_alias();
      do_wren();
      do_prog(24'hABCD40, 8'h12);
      read_chk("R10 low bits index", 24'h000040, 8'h12);
      read_chk("R10 other high bits", 24'h7F0040, 8'h12);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      t_reset();
      t_program();
      t_and();
      t_no_wel();
      t_wel_clear();
      t_wren_bits();
      t_partial();
      t_unknown();
      t_alias();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule